// File: doc/BRIEF.md
# Masked Bit-Write Command Engine

This block accepts one command packet at a time as a byte stream. Each byte comes with start-of-packet and end-of-packet flags. The packet opens with a six-byte header: destination, source, command, status, and a 16-bit transaction number. A data section follows, made of four-byte records. Each record names one byte of a byte-addressed data memory and gives two masks. One mask forces bits to 1 and the other forces bits to 0. The data memory sits outside the engine on a simple synchronous port with a read latency of one cycle.

Records are first collected in an internal store. The whole packet is checked when its last byte arrives. Only a packet that passes the check is applied. Each record then takes one read cycle and one write cycle, in arrival order. The input stream is held off with `in_ready` while the engine applies records and while it sends the reply. The reply is a six-byte packet. It swaps the two station fields, sets bit 6 of the command byte, returns a status code and echoes the transaction number.

The controller has five states:
- `ST_IDLE`: waits for a start flag and discards any byte that does not carry one.
- `ST_RECV`: collects header and record bytes.
- `ST_READ`: presents the address of the current record, or stops on an address error.
- `ST_WRITE`: writes the merged byte back.
- `ST_REPLY`: sends the reply bytes.

The transitions are:
- Start byte: `ST_IDLE` to `ST_RECV`.
- Last byte of a valid packet that holds records: `ST_RECV` to `ST_READ`.
- Last byte of an invalid or empty packet: `ST_RECV` (or `ST_IDLE` for a one-byte packet) to `ST_REPLY`.
- Address within the memory: `ST_READ` to `ST_WRITE`.
- Address out of range: `ST_READ` to `ST_REPLY`.
- More records remain: `ST_WRITE` to `ST_READ`.
- Last record written: `ST_WRITE` to `ST_REPLY`.
- Final reply byte accepted: `ST_REPLY` to `ST_IDLE`.

Top module: `mbw_engine`

## Requirements
- R1: Request byte order is destination, source, command, status, transaction low, transaction high. Each record then gives address low, address high, set mask, clear mask. The incoming status byte is ignored.
- R2: Only command 0x05 is executed. Any other command in a packet of valid length gets reply status 0x10 and causes no memory write.
- R3: Each record writes (old | set) & ~clear to its byte, so a bit that is 1 in both masks ends up 0.
- R4: Records are applied in arrival order. Each one takes a read cycle followed by a write cycle to the same address, so a later record to the same byte sees the result of an earlier one.
- R5: A data section whose length is not a multiple of 4, or that holds more than 60 records (240 bytes), gets reply status 0x20 and causes no memory write.
- R6: A record address at or above MEM_DEPTH ends execution with reply status 0x50. Earlier records stay written and later records are not applied.
- R7: The reply carries, in order, request source, request destination, command | 0x40, status, transaction low, transaction high. The start flag is on the first byte and the end flag on the sixth. Status is 0x00 on success.
- R8: `in_ready` is low from the cycle after the last request byte is accepted until the final reply byte is accepted. In `ST_IDLE`, bytes without a start flag are discarded.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R10: A header-only packet with command 0x05 gets a status 0x00 reply and causes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Engine can take a request byte |
| in_data | input | 8 | Request byte |
| in_sop | input | 1 | First byte of a request |
| in_eop | input | 1 | Last byte of a request |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Receiver takes the reply byte |
| out_data | output | 8 | Reply byte |
| out_sop | output | 1 | First reply byte |
| out_eop | output | 1 | Last reply byte |
| mem_rd_en | output | 1 | Memory read strobe; data is returned the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wdata | output | 8 | Merged byte to write |
| mem_rdata | input | 8 | Read data from the previous cycle's read |

## Verification
The hardest case to reach from the ports is an address error in the middle of a packet. The records before the bad one must be written and the records after it must not be. The stimulus places in-range records on both sides of out-of-range addresses, including one exactly at MEM_DEPTH. A full memory compare against an arithmetic model then shows where execution stopped. Repeated records to the same byte, and full 60-record sweeps with masks derived from the record index, cover the read-after-write ordering. Reply back-pressure is applied with a fixed stall pattern on every packet.

// File: rtl/mbw_pkg.sv
package mbw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_READ,
        ST_WRITE,
        ST_REPLY
    } mbw_state_t;

    localparam logic [7:0] CMD_MASKWR   = 8'h05;
    localparam logic [7:0] REPLY_BIT    = 8'h40;
    localparam logic [7:0] STS_OK       = 8'h00;
    localparam logic [7:0] STS_BAD_CMD  = 8'h10;
    localparam logic [7:0] STS_BAD_LEN  = 8'h20;
    localparam logic [7:0] STS_BAD_ADDR = 8'h50;

    localparam int HDR_BYTES   = 6;
    localparam int REC_BYTES   = 4;
    localparam int REPLY_BYTES = 6;

    // Clear mask is applied last, so it dominates the set mask.
    function automatic logic [7:0] merge_masks(input logic [7:0] old_b,
                                               input logic [7:0] set_m,
                                               input logic [7:0] clr_m);
        return (old_b | set_m) & ~clr_m;
    endfunction

endpackage

// File: rtl/mbw_rec_store.sv
module mbw_rec_store #(
    parameter int MAX_REC = 60,
    parameter int REC_AW  = $clog2(MAX_REC)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [REC_AW-1:0] wr_rec,
    input  logic [1:0]        wr_lane,
    input  logic [7:0]        wr_byte,
    input  logic [REC_AW-1:0] rd_sel,
    output logic [15:0]       rd_addr,
    output logic [7:0]        rd_set,
    output logic [7:0]        rd_clr
);

    logic [31:0] rec_flat [MAX_REC];

    for (genvar g = 0; g < MAX_REC; g++) begin : g_slot
        logic [31:0] slot_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_rec == REC_AW'(g))) begin
                slot_q[{wr_lane, 3'b000} +: 8] <= wr_byte;
            end
        end
        assign rec_flat[g] = slot_q;
    end

    assign rd_addr = rec_flat[rd_sel][15:0];
    assign rd_set  = rec_flat[rd_sel][23:16];
    assign rd_clr  = rec_flat[rd_sel][31:24];

endmodule

// File: rtl/mbw_reply_mux.sv
module mbw_reply_mux
    import mbw_pkg::*;
(
    input  logic [7:0]  req_dst,
    input  logic [7:0]  req_src,
    input  logic [7:0]  req_cmd,
    input  logic [7:0]  status,
    input  logic [15:0] tns,
    input  logic [2:0]  idx,
    output logic [7:0]  byte_o
);

    always_comb begin
        unique case (idx)
            3'd0:    byte_o = req_src;
            3'd1:    byte_o = req_dst;
            3'd2:    byte_o = req_cmd | REPLY_BIT;
            3'd3:    byte_o = status;
            3'd4:    byte_o = tns[7:0];
            default: byte_o = tns[15:8];
        endcase
    end

endmodule

// File: rtl/mbw_engine.sv
module mbw_engine
    import mbw_pkg::*;
#(
    parameter int MEM_DEPTH = 200,
    parameter int MAX_REC   = 60,
    parameter int MEM_AW    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              mem_rd_en,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    localparam int MAX_DATA = MAX_REC * REC_BYTES;
    localparam int REC_AW   = $clog2(MAX_REC);
    localparam int CNT_W    = $clog2(HDR_BYTES + MAX_DATA + 1) + 1;
    localparam int TOT_W    = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    mbw_state_t state_q, state_d;

    logic [CNT_W-1:0]  byte_cnt_q;
    logic [7:0]        dst_q, src_q, cmd_q, sts_q;
    logic [15:0]       tns_q;
    logic [REC_AW:0]   nrec_q;
    logic [REC_AW-1:0] rec_idx_q;
    logic [2:0]        rep_idx_q;

    logic              take;
    logic [CNT_W-1:0]  pos;
    logic [TOT_W-1:0]  total, data_len, data_off;
    logic              len_ok, store_rec, addr_ok, last_rec, rep_done;
    logic [7:0]        eop_sts;
    logic [15:0]       rec_addr;
    logic [7:0]        rec_set, rec_clr;

    // ---------------- byte intake ----------------
    always_comb begin
        take      = in_valid && (state_q == ST_RECV || (state_q == ST_IDLE && in_sop));
        pos       = in_sop ? '0 : byte_cnt_q;
        total     = TOT_W'(pos) + TOT_W'(1);
        data_len  = total - TOT_W'(HDR_BYTES);
        data_off  = TOT_W'(pos) - TOT_W'(HDR_BYTES);
        store_rec = take && (TOT_W'(pos) >= TOT_W'(HDR_BYTES))
                         && (data_off < TOT_W'(MAX_DATA));
        len_ok    = (total >= TOT_W'(HDR_BYTES)) && (data_len[1:0] == 2'b00)
                 && (data_len <= TOT_W'(MAX_DATA));
        if (!len_ok)                  eop_sts = STS_BAD_LEN;
        else if (cmd_q != CMD_MASKWR) eop_sts = STS_BAD_CMD;
        else                          eop_sts = STS_OK;
        addr_ok   = 32'(rec_addr) < MEM_DEPTH;
        last_rec  = ({1'b0, rec_idx_q} + 1'b1) == nrec_q;
        rep_done  = out_ready && (rep_idx_q == 3'(REPLY_BYTES - 1));
    end

    mbw_rec_store #(.MAX_REC(MAX_REC), .REC_AW(REC_AW)) u_store (
        .clk     (clk),
        .wr_en   (store_rec),
        .wr_rec  (data_off[REC_AW+1:2]),
        .wr_lane (data_off[1:0]),
        .wr_byte (in_data),
        .rd_sel  (rec_idx_q),
        .rd_addr (rec_addr),
        .rd_set  (rec_set),
        .rd_clr  (rec_clr)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RECV: begin
                if (take) begin
                    if (!in_eop)                                   state_d = ST_RECV;
                    else if (eop_sts != STS_OK || data_len == '0) state_d = ST_REPLY;
                    else                                           state_d = ST_READ;
                end
            end
            ST_READ:  state_d = addr_ok ? ST_WRITE : ST_REPLY;
            ST_WRITE: state_d = last_rec ? ST_REPLY : ST_READ;
            ST_REPLY: if (rep_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt_q <= '0;
            dst_q      <= '0;
            src_q      <= '0;
            cmd_q      <= '0;
            sts_q      <= STS_OK;
            tns_q      <= '0;
            nrec_q     <= '0;
            rec_idx_q  <= '0;
            rep_idx_q  <= '0;
        end else begin
            if (take) begin
                byte_cnt_q <= (pos == CNT_MAX) ? CNT_MAX : pos + 1'b1;
                unique case (pos)
                    CNT_W'(0): dst_q        <= in_data;
                    CNT_W'(1): src_q        <= in_data;
                    CNT_W'(2): cmd_q        <= in_data;
                    CNT_W'(4): tns_q[7:0]   <= in_data;
                    CNT_W'(5): tns_q[15:8]  <= in_data;
                    default: ;
                endcase
                if (in_eop) begin
                    sts_q     <= eop_sts;
                    nrec_q    <= data_len[REC_AW+2:2];
                    rec_idx_q <= '0;
                    rep_idx_q <= '0;
                end
            end
            if (state_q == ST_READ && !addr_ok)  sts_q     <= STS_BAD_ADDR;
            if (state_q == ST_WRITE && !last_rec) rec_idx_q <= rec_idx_q + 1'b1;
            if (state_q == ST_REPLY && out_ready) rep_idx_q <= rep_idx_q + 1'b1;
        end
    end

    // ---------------- outputs ----------------
    mbw_reply_mux u_reply (
        .req_dst (dst_q),
        .req_src (src_q),
        .req_cmd (cmd_q),
        .status  (sts_q),
        .tns     (tns_q),
        .idx     (rep_idx_q),
        .byte_o  (out_data)
    );

    always_comb begin
        in_ready  = (state_q == ST_IDLE) || (state_q == ST_RECV);
        out_valid = (state_q == ST_REPLY);
        out_sop   = out_valid && (rep_idx_q == 3'd0);
        out_eop   = out_valid && (rep_idx_q == 3'(REPLY_BYTES - 1));
        mem_rd_en = (state_q == ST_READ) && addr_ok;
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = rec_addr[MEM_AW-1:0];
        mem_wdata = merge_masks(mem_rdata, rec_set, rec_clr);
    end

endmodule

// File: rtl/mbw_engine_chk.sv
module mbw_engine_chk #(
    parameter int MEM_DEPTH = 200,
    parameter int MEM_AW    = $clog2(MEM_DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic              mem_rd_en,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic [7:0]        rec_set,
    input logic [7:0]        rec_clr
);

    AST_WE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_rd_en)); // R4
    AST_WE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(mem_addr))); // R4
    AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_rd_en)); // R4
    AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (32'(mem_addr) < MEM_DEPTH)); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_wdata & rec_clr) == 8'h00)); // R3
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_wdata & rec_set & ~rec_clr) == (rec_set & ~rec_clr))); // R3
    AST_NO_RX_WHILE_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !in_ready); // R8
    AST_NO_RX_WHILE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8
    AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sop && out_eop)); // R7

endmodule

bind mbw_engine mbw_engine_chk #(.MEM_DEPTH(MEM_DEPTH), .MEM_AW(MEM_AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .mem_rd_en (mem_rd_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rec_set   (rec_set),
    .rec_clr   (rec_clr)
);

// File: tb/mbw_engine_tb.sv
`timescale 1ns/1ps
module mbw_engine_tb_top;

    localparam int DEPTH = 200;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          out_valid, out_sop, out_eop;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          mem_rd_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;

    logic [7:0] ram     [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    logic [7:0] pl      [512];
    int         plen;

    always #2 clk = ~clk;

    mbw_engine #(.MEM_DEPTH(DEPTH), .MAX_REC(60)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop),
        .mem_rd_en(mem_rd_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= ram[mem_addr];
        if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            wr_cnt        <= wr_cnt + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic pkt_begin(input int d, input int s, input int c, input int t);
        pl[0] = 8'(d); pl[1] = 8'(s); pl[2] = 8'(c); pl[3] = 8'h77;
        pl[4] = 8'(t); pl[5] = 8'(t >> 8);
        plen = 6;
    endtask

    task automatic pkt_rec(input int a, input int s, input int c);
        pl[plen]   = 8'(a);
        pl[plen+1] = 8'(a >> 8);
        pl[plen+2] = 8'(s);
        pl[plen+3] = 8'(c);
        plen += 4;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_sop = s; in_eop = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    // Model from the requirements, send the packet, collect and check the reply.
    task automatic run_pkt(input string tag);
        int          dlen, nrec, a, ew, w0, n, cyc, bad;
        logic [7:0]  sts;
        logic [7:0]  er [6];
        logic [7:0]  got [6];
        logic        bp_bad, flag_bad, hold_bad, stalled;
        logic [7:0]  held;
        // model (R1, R2, R3, R5, R6, R10)
        dlen = plen - 6;
        ew   = 0;
        if (plen < 6 || (dlen % 4) != 0 || dlen > 240) sts = 8'h20;
        else if (pl[2] != 8'h05)                      sts = 8'h10;
        else begin
            sts  = 8'h00;
            nrec = dlen / 4;
            for (int r = 0; r < nrec; r++) begin
                a = int'(pl[6+4*r]) + 256 * int'(pl[7+4*r]);
                if (a >= DEPTH) begin sts = 8'h50; break; end
                exp_mem[a] = (exp_mem[a] | pl[8+4*r]) & ~pl[9+4*r];
                ew++;
            end
        end
        er[0] = pl[1]; er[1] = pl[0]; er[2] = pl[2] | 8'h40; er[3] = sts;
        er[4] = pl[4]; er[5] = pl[5];
        // send
        w0 = wr_cnt;
        for (int i = 0; i < plen; i++) send_byte(pl[i], i == 0, i == plen - 1);
        // receive with a stall pattern on out_ready (R9)
        n = 0; cyc = 0; bp_bad = 0; flag_bad = 0; hold_bad = 0; stalled = 0; held = '0;
        while (n < 6) begin
            @(negedge clk);
            if (stalled && (!out_valid || out_data != held)) hold_bad = 1;
            out_ready = (cyc % 3) != 1;
            if (in_ready) bp_bad = 1;
            stalled = out_valid && !out_ready;
            held    = out_data;
            if (out_valid && out_ready) begin
                got[n] = out_data;
                if (out_sop != (n == 0) || out_eop != (n == 5)) flag_bad = 1;
                n++;
            end
            cyc++;
            if (cyc > 2000) break;
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(n == 6, {tag, " R7 reply byte count"}, n, 6);
        for (int i = 0; i < 6; i++)
            chk(got[i] == er[i], $sformatf("%s R7 reply byte %0d", tag, i), got[i], er[i]);
        chk(!flag_bad, {tag, " R7 sop/eop placement"}, flag_bad, 0);
        chk(!bp_bad, {tag, " R8 in_ready low until reply done"}, bp_bad, 0);
        chk(!hold_bad, {tag, " R9 reply held under stall"}, hold_bad, 0);
        chk(in_ready, {tag, " R8 in_ready back after reply"}, in_ready, 1);
        chk(wr_cnt - w0 == ew, {tag, " R4 write count"}, wr_cnt - w0, ew);
        bad = -1;
        for (int i = 0; i < DEPTH; i++) if (ram[i] != exp_mem[i] && bad < 0) bad = i;
        chk(bad < 0, {tag, " R3 memory contents"}, (bad < 0) ? 0 : ram[bad],
            (bad < 0) ? 0 : exp_mem[bad]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ram[i]     = 8'(i * 37 + 5);
            exp_mem[i] = 8'(i * 37 + 5);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R8 reset in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
        chk(mem_we == 1'b0 && mem_rd_en == 1'b0, "R4 reset memory idle", mem_we, 0);

        // R1/R3 single record
        pkt_begin(8'h11, 8'h22, 8'h05, 16'h1234);
        pkt_rec(10, 8'hF0, 8'h0F);
        run_pkt("single");

        // R3 overlapping masks, clear wins
        pkt_begin(8'h01, 8'h02, 8'h05, 16'h0001);
        pkt_rec(0, 8'hFF, 8'h5A);
        pkt_rec(1, 8'h3C, 8'h3C);
        run_pkt("overlap");

        // R4 repeated address: each record sees the previous result
        pkt_begin(8'h03, 8'h04, 8'h05, 16'h0002);
        pkt_rec(5, 8'h00, 8'hFF);
        pkt_rec(5, 8'h81, 8'h00);
        pkt_rec(5, 8'h0F, 8'h01);
        pkt_rec(5, 8'h40, 8'h08);
        run_pkt("same-addr");

        // R4/R3 full-size sweeps, 60 records each
        for (int p = 0; p < 8; p++) begin
            pkt_begin(p, 8'hA0 + p, 8'h05, 16'hBE00 + p);
            for (int r = 0; r < 60; r++)
                pkt_rec((r * 7 + p * 13) % DEPTH, (r * 37 + p * 11) & 255, (r * 91 + p * 29) & 255);
            run_pkt($sformatf("sweep%0d", p));
        end

        // R10 header-only packet
        pkt_begin(8'h55, 8'h66, 8'h05, 16'hFFFF);
        run_pkt("empty");

        // R2 other command
        pkt_begin(8'h07, 8'h08, 8'h0F, 16'h0303);
        pkt_rec(20, 8'hFF, 8'h00);
        pkt_rec(21, 8'h00, 8'hFF);
        run_pkt("bad-cmd");

        // R5 length not a multiple of four
        pkt_begin(8'h09, 8'h0A, 8'h05, 16'h0404);
        pkt_rec(30, 8'hFF, 8'h00);
        pl[plen] = 8'h01; pl[plen+1] = 8'h02; pl[plen+2] = 8'h03;
        plen += 3;
        run_pkt("len7");

        // R5 sixty-one records
        pkt_begin(8'h0B, 8'h0C, 8'h05, 16'h0505);
        for (int r = 0; r < 61; r++) pkt_rec(r, 8'hFF, 8'h00);
        run_pkt("rec61");

        // R6 address at the limit, then beyond it
        pkt_begin(8'h0D, 8'h0E, 8'h05, 16'h0606);
        pkt_rec(3, 8'h0F, 8'hF0);
        pkt_rec(DEPTH - 1, 8'hAA, 8'h11);
        pkt_rec(DEPTH, 8'hFF, 8'h00);
        pkt_rec(4, 8'hFF, 8'h00);
        run_pkt("addr-edge");

        pkt_begin(8'h0F, 8'h10, 8'h05, 16'h0707);
        pkt_rec(6, 8'h01, 8'h00);
        pkt_rec(16'hFFFF, 8'hFF, 8'h00);
        run_pkt("addr-high");

        // R8 stray bytes without a start flag are discarded
        send_byte(8'hDE, 1'b0, 1'b0);
        send_byte(8'hAD, 1'b0, 1'b1);
        @(negedge clk);
        chk(in_ready && !out_valid, "R8 stray bytes ignored", out_valid, 0);
        pkt_begin(8'hC1, 8'hC2, 8'h05, 16'hBEEF);
        pkt_rec(50, 8'h0C, 8'h03);
        run_pkt("after-stray");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule